// File: doc/BRIEF.md
# Coprocessor Control Registers with DMA Channel Shadowing

This block sits on the register side of a cartridge coprocessor attached to an 8-bit CPU bus with a 24-bit address, split into an 8-bit bank and a 16-bit offset. It answers a small eight-byte window of its own. That window holds a DMA processing enable byte, a byte that arms processing of the next DMA, and four ROM bank-select bytes. All of them are exposed as parallel outputs for the bank-mapping and decompression logic further down the chip.

The block also listens passively to CPU writes aimed at the host DMA controller's per-channel registers. From those writes it keeps a shadow copy of every channel's 24-bit source address and 16-bit transfer length. The block never takes such writes over: whenever it does not claim an access, it raises a pass-through flag in the same cycle, so that the normal register handler serves the access. Data from a claimed read appears one clock after the read strobe.

Top module: `cpr_ctrl_regs`

## Requirements
- R1: After reset, bank-select registers 0..3 hold 0, 1, 2 and 3. The enable byte, the next-DMA byte, every shadowed channel address and length, and the read data all hold zero.
- R2: Offset 0x4800 holds the 8-bit DMA processing enable and offset 0x4801 holds the 8-bit next-DMA byte. Both store any written value and read it back unchanged.
- R3: Offsets 0x4804 to 0x4807 are bank-select registers 0 to 3, chosen by address bits 1:0. Each stores and reads back its byte, and bank register k drives bits 8k+7:8k of the bank-select output.
- R4: A claimed read returns its data on the read-data output from the clock edge that samples the strobe, and the read-data output holds that value until the next claimed read.
- R5: The window and the snooping respond only in banks 0x00–0x3F and 0x80–0xBF. An access in any other bank is passed through and changes no state.
- R6: The pass-through flag is combinational and is high in the cycle of any read or write that the block does not claim. It is low when the bus is idle. A write inside 0x4300–0x437A is passed through even though the block snoops it.
- R7: A write at offset 0x4300–0x437A updates the shadow of channel addr[6:4]. Low nibble 2, 3 and 4 replace address bits 7:0, 15:8 and 23:16. Low nibble 5 and 6 replace length bits 7:0 and 15:8. Channel c occupies bits 24c+23:24c of the address output and bits 16c+15:16c of the length output.
- R8: A snooped-range write whose low nibble is 0, 1 or 7 to F leaves every channel's shadow unchanged.
- R9: Offsets 0x4802 and 0x4803 are holes. Reads there are passed through. Writes there are claimed: they are not passed through and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | CPU address, bank in bits 23:16 |
| bus_wdata | input | 8 | CPU write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data of the last claimed read |
| passthru | output | 1 | Access not claimed; normal handler serves it |
| dma_en_o | output | 8 | DMA processing enable byte |
| dma_next_o | output | 8 | Next-DMA byte |
| bank_sel_o | output | 32 | Four bank-select bytes, register 0 in bits 7:0 |
| dma_addr_o | output | 192 | Eight shadowed 24-bit channel addresses |
| dma_len_o | output | 128 | Eight shadowed 16-bit channel lengths |

## Verification
The assertions check on every cycle the properties that do not depend on stored values. The pass-through flag is low when the bus is idle and high for off-page accesses, foreign banks and hole reads. No stored byte moves without a write, the read data moves only on a read, and writes in foreign banks leave all state frozen. Only the bench scenarios can show the rest: the reset values, byte-exact readback of each register, the placement of every snooped byte on each of the eight channels, and the fact that writes with the remaining nibbles, or writes to the holes, change nothing.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
    localparam int DATA_W    = 8;
    localparam int BUS_AW    = 24;
    localparam int NUM_CH    = 8;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int NUM_BANKS = 4;
    localparam int IDX_W     = 3;

    localparam logic [15:0] WIN_BASE = 16'h4800;
    localparam logic [15:0] SNOOP_LO = 16'h4300;
    localparam logic [15:0] SNOOP_HI = 16'h437A;

    typedef enum logic [2:0] {
        FLD_NONE,
        FLD_ADDR0,
        FLD_ADDR1,
        FLD_ADDR2,
        FLD_LEN0,
        FLD_LEN1
    } snoop_fld_e;
endpackage

// File: rtl/cpr_decode.sv
module cpr_decode
    import cpr_pkg::*;
(
    input  logic [BUS_AW-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              own_rd,
    output logic              own_wr,
    output logic [IDX_W-1:0]  idx,
    output logic              snoop_wr,
    output logic [CH_W-1:0]   ch,
    output snoop_fld_e        fld,
    output logic              pass
);
    logic [7:0]  bank;
    logic [15:0] off;
    logic        bank_ok;
    logic        in_win;
    logic        readable;

    always_comb begin
        bank     = addr[BUS_AW-1:16];
        off      = addr[15:0];
        bank_ok  = (bank <= 8'h3F) || ((bank >= 8'h80) && (bank <= 8'hBF));
        in_win   = bank_ok && (off[15:IDX_W] == WIN_BASE[15:IDX_W]);
        idx      = off[IDX_W-1:0];
        readable = (idx != 3'd2) && (idx != 3'd3);
        own_rd   = rd && in_win && readable;
        own_wr   = wr && in_win;
        snoop_wr = wr && bank_ok && (off >= SNOOP_LO) && (off <= SNOOP_HI);
        ch       = off[4 +: CH_W];
        unique case (off[3:0])
            4'h2:    fld = FLD_ADDR0;
            4'h3:    fld = FLD_ADDR1;
            4'h4:    fld = FLD_ADDR2;
            4'h5:    fld = FLD_LEN0;
            4'h6:    fld = FLD_LEN1;
            default: fld = FLD_NONE;
        endcase
        pass = (rd && !own_rd) || (wr && !own_wr);
    end
endmodule

// File: rtl/cpr_own_regs.sv
module cpr_own_regs #(
    parameter int DATA_W    = 8,
    parameter int NUM_BANKS = 4,
    parameter int IDX_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        own_wr,
    input  logic                        own_rd,
    input  logic [IDX_W-1:0]            idx,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           en_o,
    output logic [DATA_W-1:0]           next_o,
    output logic [NUM_BANKS*DATA_W-1:0] bank_o,
    output logic [DATA_W-1:0]           rdata_o
);
    localparam int BSEL_W = $clog2(NUM_BANKS);

    typedef struct packed {
        logic [DATA_W-1:0]                 en;
        logic [DATA_W-1:0]                 nxt;
        logic [NUM_BANKS-1:0][DATA_W-1:0]  bank;
        logic [DATA_W-1:0]                 rdata;
    } own_st_t;

    own_st_t st_d, st_q, st_rst;

    always_comb begin
        st_rst = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            st_rst.bank[i] = DATA_W'(i);
        end
    end

    always_comb begin
        st_d = st_q;
        if (own_wr) begin
            case (idx)
                3'd0: st_d.en  = wdata;
                3'd1: st_d.nxt = wdata;
                default: begin
                    if (idx[2]) begin
                        st_d.bank[idx[BSEL_W-1:0]] = wdata;
                    end
                end
            endcase
        end
        if (own_rd) begin
            case (idx)
                3'd0:    st_d.rdata = st_q.en;
                3'd1:    st_d.rdata = st_q.nxt;
                default: st_d.rdata = idx[2] ? st_q.bank[idx[BSEL_W-1:0]] : '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign next_o  = st_q.nxt;
    assign bank_o  = st_q.bank;
    assign rdata_o = st_q.rdata;
endmodule

// File: rtl/cpr_dma_shadow.sv
module cpr_dma_shadow
    import cpr_pkg::*;
#(
    parameter int NCH = 8,
    parameter int DW  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snoop_wr,
    input  logic [$clog2(NCH)-1:0]  ch,
    input  snoop_fld_e              fld,
    input  logic [DW-1:0]           wdata,
    output logic [NCH*3*DW-1:0]     addr_o,
    output logic [NCH*2*DW-1:0]     len_o
);
    localparam int AW = 3 * DW;
    localparam int LW = 2 * DW;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [LW-1:0] len;
    } chan_t;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chan_t c_d, c_q;
        logic  hit;

        always_comb begin
            hit = snoop_wr && (ch == g);
            c_d = c_q;
            if (hit) begin
                case (fld)
                    FLD_ADDR0: c_d.addr[DW-1:0]      = wdata;
                    FLD_ADDR1: c_d.addr[2*DW-1:DW]   = wdata;
                    FLD_ADDR2: c_d.addr[3*DW-1:2*DW] = wdata;
                    FLD_LEN0:  c_d.len[DW-1:0]       = wdata;
                    FLD_LEN1:  c_d.len[2*DW-1:DW]    = wdata;
                    default:   c_d = c_q;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c_q <= '0;
            end else begin
                c_q <= c_d;
            end
        end

        assign addr_o[g*AW +: AW] = c_q.addr;
        assign len_o[g*LW +: LW]  = c_q.len;
    end
endmodule

// File: rtl/cpr_ctrl_regs.sv
module cpr_ctrl_regs
    import cpr_pkg::*;
#(
    parameter int DW = cpr_pkg::DATA_W,
    parameter int NB = cpr_pkg::NUM_BANKS,
    parameter int NC = cpr_pkg::NUM_CH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    output logic [DW-1:0]        bus_rdata,
    output logic                 passthru,
    output logic [DW-1:0]        dma_en_o,
    output logic [DW-1:0]        dma_next_o,
    output logic [NB*DW-1:0]     bank_sel_o,
    output logic [NC*3*DW-1:0]   dma_addr_o,
    output logic [NC*2*DW-1:0]   dma_len_o
);
    logic              own_rd, own_wr, snoop_wr;
    logic [IDX_W-1:0]  idx;
    logic [CH_W-1:0]   ch;
    snoop_fld_e        fld;

    cpr_decode u_dec (
        .addr     (bus_addr),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .own_rd   (own_rd),
        .own_wr   (own_wr),
        .idx      (idx),
        .snoop_wr (snoop_wr),
        .ch       (ch),
        .fld      (fld),
        .pass     (passthru)
    );

    cpr_own_regs #(
        .DATA_W    (DW),
        .NUM_BANKS (NB),
        .IDX_W     (IDX_W)
    ) u_own (
        .clk     (clk),
        .rst_n   (rst_n),
        .own_wr  (own_wr),
        .own_rd  (own_rd),
        .idx     (idx),
        .wdata   (bus_wdata),
        .en_o    (dma_en_o),
        .next_o  (dma_next_o),
        .bank_o  (bank_sel_o),
        .rdata_o (bus_rdata)
    );

    cpr_dma_shadow #(
        .NCH (NC),
        .DW  (DW)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .snoop_wr (snoop_wr),
        .ch       (ch),
        .fld      (fld),
        .wdata    (bus_wdata),
        .addr_o   (dma_addr_o),
        .len_o    (dma_len_o)
    );
endmodule

// File: rtl/cpr_ctrl_regs_chk.sv
module cpr_ctrl_regs_chk #(
    parameter int DW = 8,
    parameter int NB = 4,
    parameter int NC = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [23:0]        bus_addr,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [DW-1:0]      bus_rdata,
    input logic               passthru,
    input logic [DW-1:0]      dma_en_o,
    input logic [DW-1:0]      dma_next_o,
    input logic [NB*DW-1:0]   bank_sel_o,
    input logic [NC*3*DW-1:0] dma_addr_o,
    input logic [NC*2*DW-1:0] dma_len_o
);
    logic foreign_bank;
    assign foreign_bank = (bus_addr[23:16] >= 8'h40 && bus_addr[23:16] <= 8'h7F)
                       || (bus_addr[23:16] >= 8'hC0);

    AST_IDLE_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd || bus_wr) |-> !passthru);                                   // R6
    AST_OFF_PAGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_addr[15:8] != 8'h48) |-> passthru);        // R6
    AST_HOLE_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[15:3] == 13'h0900 && bus_addr[2:1] == 2'b01) |-> passthru); // R9
    AST_FOREIGN_BANK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && foreign_bank) |-> passthru);                   // R5
    AST_FOREIGN_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && foreign_bank) |=> ($stable(dma_en_o) && $stable(dma_next_o)
            && $stable(bank_sel_o) && $stable(dma_addr_o) && $stable(dma_len_o))); // R5
    AST_OWN_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(dma_en_o) && $stable(dma_next_o) && $stable(bank_sel_o))); // R2
    AST_SHADOW_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(dma_addr_o) && $stable(dma_len_o)));             // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));                                      // R4
endmodule

bind cpr_ctrl_regs cpr_ctrl_regs_chk #(.DW(DW), .NB(NB), .NC(NC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .passthru   (passthru),
    .dma_en_o   (dma_en_o),
    .dma_next_o (dma_next_o),
    .bank_sel_o (bank_sel_o),
    .dma_addr_o (dma_addr_o),
    .dma_len_o  (dma_len_o)
);

// File: tb/sim_cpr_ctrl_regs.sv
`timescale 1ns/1ps
module sim_cpr_ctrl_regs;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [23:0]  bus_addr = '0;
    logic [7:0]   bus_wdata = '0;
    logic         bus_rd = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_rdata;
    logic         passthru;
    logic [7:0]   dma_en_o, dma_next_o;
    logic [31:0]  bank_sel_o;
    logic [191:0] dma_addr_o;
    logic [127:0] dma_len_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_en, m_next;
    logic [7:0]  m_bank [4];
    logic [23:0] m_addr [8];
    logic [15:0] m_len  [8];

    typedef struct {
        bit         claim;
        logic [7:0] data;
        string      tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #2 clk = ~clk;

    cpr_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .passthru(passthru),
        .dma_en_o(dma_en_o), .dma_next_o(dma_next_o), .bank_sel_o(bank_sel_o),
        .dma_addr_o(dma_addr_o), .dma_len_o(dma_len_o)
    );

    task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        for (int i = 0; i < 4; i++)
            chk({tag, " bank"}, 192'(bank_sel_o[8*i +: 8]), 192'(m_bank[i]));
        chk({tag, " en"}, 192'(dma_en_o), 192'(m_en));
        chk({tag, " next"}, 192'(dma_next_o), 192'(m_next));
        for (int c = 0; c < 8; c++) begin
            chk({tag, " addr"}, 192'(dma_addr_o[24*c +: 24]), 192'(m_addr[c]));
            chk({tag, " len"}, 192'(dma_len_o[16*c +: 16]), 192'(m_len[c]));
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic wr(input logic [23:0] a, input logic [7:0] d, input bit exp_pass, input string tag);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1 chk({tag, " passthru"}, 192'(passthru), 192'(exp_pass));
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, input bit claim, input logic [7:0] exp, input string tag);
        rd_item_t it;
        it.claim = claim; it.data = exp; it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        #1 chk({tag, " passthru"}, 192'(passthru), 192'(!claim));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // monitor: pops one expected item per read strobe, compares after the edge
    initial begin
        forever begin
            @(posedge clk);
            if (bus_rd && sb_q.size() > 0) begin
                rd_item_t it;
                it = sb_q.pop_front();
                @(negedge clk);
                if (it.claim) chk({it.tag, " rdata"}, 192'(bus_rdata), 192'(it.data));
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_en = 0; m_next = 0;
        for (int i = 0; i < 4; i++) m_bank[i] = 8'(i);
        for (int c = 0; c < 8; c++) begin m_addr[c] = 0; m_len[c] = 0; end

        repeat (3) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check_state("R1 reset");
        chk("R1 rdata", 192'(bus_rdata), 192'(0));
        chk("R6 idle passthru", 192'(passthru), 192'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3: own registers in bank 0x00 and 0x80
        wr(24'h004800, 8'hA5, 0, "R2 en"); m_en = 8'hA5;
        wr(24'h804801, 8'h3C, 0, "R2 next"); m_next = 8'h3C;
        for (int i = 0; i < 4; i++) begin
            wr({(i[0] ? 8'hBF : 8'h12), 16'h4804 + 16'(i)}, 8'hE0 + 8'(i * 5), 0, "R3 bank");
            m_bank[i] = 8'hE0 + 8'(i * 5);
        end
        check_state("R3 after writes");
        rd(24'h004800, 1, 8'hA5, "R2 R4 read en");
        rd(24'h3F4801, 1, 8'h3C, "R2 R4 read next");
        for (int i = 0; i < 4; i++)
            rd({8'h80, 16'h4804 + 16'(i)}, 1, m_bank[i], "R3 R4 read bank");
        rd(24'h004802, 0, 8'h00, "R9 hole read");
        rd(24'h002100, 0, 8'h00, "R6 foreign read");
        @(negedge clk);
        chk("R4 rdata holds", 192'(bus_rdata), 192'(m_bank[3]));

        // R9: hole writes claimed, no effect
        wr(24'h004802, 8'hFF, 0, "R9 hole wr");
        wr(24'h804803, 8'hFF, 0, "R9 hole wr");
        check_state("R9 after hole writes");

        // R5: foreign banks
        wr(24'h404800, 8'h11, 1, "R5 bank40");
        wr(24'hC04805, 8'h22, 1, "R5 bankC0");
        wr(24'h7F4302, 8'h33, 1, "R5 snoop bank7F");
        rd(24'hFF4800, 0, 8'h00, "R5 read bankFF");
        check_state("R5 after foreign");

        // R7: snoop each channel, all five fields; passthru high (R6)
        for (int c = 0; c < 8; c++) begin
            logic [15:0] base;
            base = 16'h4300 + 16'(c << 4);
            wr({8'h00, base + 16'h2}, 8'h10 + 8'(c), 1, "R7 R6 snoop a0");
            wr({8'h80, base + 16'h3}, 8'h50 + 8'(c), 1, "R7 R6 snoop a1");
            wr({8'h3F, base + 16'h4}, 8'hA0 + 8'(c), 1, "R7 R6 snoop a2");
            wr({8'hBF, base + 16'h5}, 8'h30 + 8'(c), 1, "R7 R6 snoop l0");
            wr({8'h01, base + 16'h6}, 8'hC0 + 8'(c), 1, "R7 R6 snoop l1");
            m_addr[c] = {8'hA0 + 8'(c), 8'h50 + 8'(c), 8'h10 + 8'(c)};
            m_len[c]  = {8'hC0 + 8'(c), 8'h30 + 8'(c)};
        end
        check_state("R7 after snoop");
        wr(24'h004352, 8'h99, 1, "R7 overwrite");
        m_addr[5][7:0] = 8'h99;
        check_state("R7 overwrite");

        // R8: other nibbles leave shadows unchanged
        for (int c = 0; c < 8; c++) begin
            for (int n = 0; n < 16; n++) begin
                if (n < 2 || n > 6)
                    wr({8'h00, 16'h4300 + 16'(c << 4) + 16'(n)}, 8'h5A, 1, "R8 other nibble");
            end
        end
        check_state("R8 after other nibbles");
        rd(24'h004804, 1, m_bank[0], "R3 final bank0");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule